// File: doc/BRIEF.md
# Ethernet Controller Host Register Port

This block is the host-facing register file of a bus-mastering Ethernet controller. The host reaches every register through two ports. A write to the address port picks a register number. Reads and writes on the data port then go to that register until the address port is written again. The registers are:

- register 0, the status and command word;
- registers 1 and 2, the low and high halves of the init-block pointer;
- register 3, the bus-control bits;
- registers 8 to 11, four address-filter words;
- register 15, the mode word.

Each bit of the status word follows its own write rule. Command bits are set by writing one. Cause bits are cleared by writing one. The enable bit is plain read/write, and the summary bits are read-only.

The transmit, receive and init engines report events as one-cycle pulses, and these pulses set the cause bits. The block sends one-cycle command strobes back to the engines and drives an active-high interrupt. A stop command takes priority over everything else. It returns the engine state and the bus-control bits to their defaults. The configuration registers can only be changed while the controller is stopped.

Top module: `eth_csr_port`

## Requirements
- R1: A data-port write (hostAddrSel=0) goes to the register whose number was last written to the address port (hostAddrSel=1, low 4 bits). The number stays selected until the address port is rewritten. hostRdData always shows the selected register. Register numbers 4 to 7 and 12 to 14 read 0 and ignore writes.
- R2: After reset, the status word reads 0x0004 (only STOP is set). All other registers, outputs and the selected register number are 0.
- R3: In the status word (register 0), writing 1 to bit 0 (INIT), bit 1 (STRT) or bit 3 (TDMD) sets that bit, and writing 0 has no effect. Setting INIT or STRT clears STOP (bit 2). Setting STRT also sets TXON (bit 4) and RXON (bit 5).
- R4: A status write with bit 2 (STOP) set has priority over the other bits in that write. It sets STOP and clears INIT, STRT, TDMD, TXON, RXON and all cause bits. Writing 0x0005 therefore reads back as 0x0004.
- R5: Event pulses set the cause bits as follows: initDoneEvt→IDON (bit 8), txDoneEvt→TINT (9), rxDoneEvt→RINT (10), memErrEvt→MERR (11), missEvt→MISS (12), carrierErrEvt→CERR (13), babbleEvt→BABL (14). Writing 1 to a cause bit clears it and writing 0 leaves it unchanged. If a pulse and a clear arrive in the same cycle, the pulse wins. Pulses are ignored while STOP is set or is being written.
- R6: ERR (bit 15) reads as the OR of MERR, MISS, CERR and BABL. Writes to bits 4, 5, 7 and 15 have no effect.
- R7: INTR (bit 7) reads as the OR of IDON, TINT, RINT, MERR, MISS and BABL (CERR is excluded). INEA (bit 6) is read/write. irqOut equals INTR AND INEA.
- R8: Registers 1, 2, 3, 8 to 11 and 15 accept writes only while STOP is set. At other times writes to them are ignored. initAddr shows {register 2, register 1}.
- R9: Register 3 holds byte control (bit 0), address-latch control (bit 1) and byte swap (bit 2). It appears on busCtrl. Any status write with STOP set returns it to 0.
- R10: filterBits carries filter word k (register 8+k) at bits 16k+15:16k. promiscOn equals bit 15 of register 15.
- R11: In the cycle after a status write, stopCmd pulses if bit 2 was set. If bit 2 was clear, initCmd, startCmd and txDemandCmd pulse for bits 0, 1 and 3.
- R12: TDMD is cleared by an accepted txDoneEvt pulse unless TDMD is written to 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddrSel | input | 1 | 1 = address port, 0 = data port |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Contents of the selected register |
| initDoneEvt | input | 1 | Init engine finished |
| txDoneEvt | input | 1 | Transmit descriptor done |
| rxDoneEvt | input | 1 | Receive descriptor done |
| memErrEvt | input | 1 | Memory access error |
| missEvt | input | 1 | Frame missed |
| carrierErrEvt | input | 1 | Carrier/heartbeat error |
| babbleEvt | input | 1 | Transmitter babble |
| irqOut | output | 1 | Interrupt request, active high |
| initCmd | output | 1 | Init command strobe |
| startCmd | output | 1 | Start command strobe |
| stopCmd | output | 1 | Stop command strobe |
| txDemandCmd | output | 1 | Transmit-demand strobe |
| initAddr | output | 32 | Init-block pointer {high, low} |
| busCtrl | output | 3 | Bus-control bits |
| filterBits | output | 64 | Four filter words |
| promiscOn | output | 1 | Promiscuous reception selected |

## Verification
A behavioural model in the bench follows every write and event pulse and is compared with all outputs on each cycle. The stimulus exercises:

- configuration writes while stopped and while running, which separates gating on the STOP bit from the address decode alone;
- unassigned register numbers and writes of zero, which show whether undefined or zero writes disturb state;
- an event pulse landing in the same cycle as a clear of its own bit, and a STOP write landing in the same cycle as a babble pulse, which expose the priority order;
- a carrier error on its own against a memory error, which tells the error summary apart from the interrupt summary;
- a transmit-done pulse after a demand, which shows that TDMD is released only by the accepted event.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
  parameter int FILTER_WORDS = 4;
  parameter int FILTER_BASE = 8;
  parameter int BUS_W = 3;

  localparam int REG_STATUS = 0;
  localparam int REG_PTR_LO = 1;
  localparam int REG_PTR_HI = 2;
  localparam int REG_BUS = 3;
  localparam int REG_MODE = 15;

  // status word bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_INEA = 6;
  localparam int B_CAUSE_LO = 8;
  localparam int B_CAUSE_HI = 14;
  localparam int NUM_CAUSE = B_CAUSE_HI - B_CAUSE_LO + 1;

  // write strobes from the decode side to the register side
  typedef struct packed {
    logic statusWr;
    logic ptrLoWr;
    logic ptrHiWr;
    logic busWr;
    logic [FILTER_WORDS-1:0] filterWr;
    logic modeWr;
  } wrStrobes_t;
endpackage

// File: rtl/eth_csr_ctrl.sv
module eth_csr_ctrl
  import eth_csr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostAddrSel,
  input  logic [ADDR_W-1:0] addrData,
  input  logic              stopNow,
  output logic [ADDR_W-1:0] curAddr,
  output wrStrobes_t        wrS
);
  logic dataWr;
  logic cfgOk;
  logic [FILTER_WORDS-1:0] filterHit;

  always_ff @(posedge clk) begin
    if (!rstN) curAddr <= '0;
    else if (hostWrEn && hostAddrSel) curAddr <= addrData;
  end

  assign dataWr = hostWrEn && !hostAddrSel;
  assign cfgOk = dataWr && stopNow;

  for (genvar k = 0; k < FILTER_WORDS; k++) begin : g_fhit
    assign filterHit[k] = cfgOk && (curAddr == ADDR_W'(FILTER_BASE + k));
  end

  always_comb begin
    wrS.statusWr = dataWr && (curAddr == ADDR_W'(REG_STATUS));
    wrS.ptrLoWr  = cfgOk && (curAddr == ADDR_W'(REG_PTR_LO));
    wrS.ptrHiWr  = cfgOk && (curAddr == ADDR_W'(REG_PTR_HI));
    wrS.busWr    = cfgOk && (curAddr == ADDR_W'(REG_BUS));
    wrS.filterWr = filterHit;
    wrS.modeWr   = cfgOk && (curAddr == ADDR_W'(REG_MODE));
  end
endmodule

// File: rtl/eth_csr_regs.sv
module eth_csr_regs
  import eth_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  wrStrobes_t                     wrS,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              curAddr,
  input  logic [NUM_CAUSE-1:0]           evtVec,
  output logic                           stopNow,
  output logic [DATA_W-1:0]              statusWord,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irqOut,
  output logic                           initCmd,
  output logic                           startCmd,
  output logic                           stopCmd,
  output logic                           txDemandCmd,
  output logic [2*DATA_W-1:0]            initAddr,
  output logic [BUS_W-1:0]               busCtrl,
  output logic [FILTER_WORDS*DATA_W-1:0] filterBits,
  output logic                           promiscOn
);
  logic initQ, strtQ, stopQ, tdmdQ, txOnQ, rxOnQ, ineaQ;
  logic [NUM_CAUSE-1:0] causeQ, acceptEvt, clrVec;
  logic cmdStop, cmdInit, cmdStrt, cmdTdmd;
  logic errSum, intrSum;
  logic [DATA_W-1:0] ptrLoQ, ptrHiQ, modeQ;
  logic [BUS_W-1:0] busQ;
  logic [DATA_W-1:0] filterQ [FILTER_WORDS];

  assign cmdStop = wrS.statusWr && wrData[B_STOP];
  assign cmdInit = wrS.statusWr && wrData[B_INIT] && !wrData[B_STOP];
  assign cmdStrt = wrS.statusWr && wrData[B_STRT] && !wrData[B_STOP];
  assign cmdTdmd = wrS.statusWr && wrData[B_TDMD] && !wrData[B_STOP];
  assign acceptEvt = (stopQ || cmdStop) ? '0 : evtVec;
  assign clrVec = wrS.statusWr ? wrData[B_CAUSE_HI:B_CAUSE_LO] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {initQ, strtQ, tdmdQ, txOnQ, rxOnQ, ineaQ} <= '0;
      stopQ  <= 1'b1;
      causeQ <= '0;
      {initCmd, startCmd, stopCmd, txDemandCmd} <= '0;
    end else begin
      initCmd     <= cmdInit;
      startCmd    <= cmdStrt;
      stopCmd     <= cmdStop;
      txDemandCmd <= cmdTdmd;
      if (wrS.statusWr) ineaQ <= wrData[B_INEA];
      if (cmdStop) begin
        {initQ, strtQ, tdmdQ, txOnQ, rxOnQ} <= '0;
        stopQ  <= 1'b1;
        causeQ <= '0;
      end else begin
        if (cmdInit) initQ <= 1'b1;
        if (cmdStrt) begin
          strtQ <= 1'b1;
          txOnQ <= 1'b1;
          rxOnQ <= 1'b1;
        end
        if (cmdInit || cmdStrt) stopQ <= 1'b0;
        if (cmdTdmd) tdmdQ <= 1'b1;
        else if (acceptEvt[1]) tdmdQ <= 1'b0;
        causeQ <= (causeQ & ~clrVec) | acceptEvt;
      end
    end
  end

  // cause index: 0 IDON,1 TINT,2 RINT,3 MERR,4 MISS,5 CERR,6 BABL
  assign errSum  = |causeQ[6:3];
  assign intrSum = causeQ[6] | (|causeQ[4:0]);
  assign statusWord = {errSum, causeQ, intrSum, ineaQ, rxOnQ, txOnQ,
                       tdmdQ, stopQ, strtQ, initQ};
  assign irqOut  = intrSum && ineaQ;
  assign stopNow = stopQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrLoQ <= '0;
      ptrHiQ <= '0;
      modeQ  <= '0;
      busQ   <= '0;
    end else begin
      if (wrS.ptrLoWr) ptrLoQ <= wrData;
      if (wrS.ptrHiWr) ptrHiQ <= wrData;
      if (wrS.modeWr) modeQ <= wrData;
      if (cmdStop) busQ <= '0;
      else if (wrS.busWr) busQ <= wrData[BUS_W-1:0];
    end
  end

  for (genvar k = 0; k < FILTER_WORDS; k++) begin : g_filt
    always_ff @(posedge clk) begin
      if (!rstN) filterQ[k] <= '0;
      else if (wrS.filterWr[k]) filterQ[k] <= wrData;
    end
    assign filterBits[k*DATA_W +: DATA_W] = filterQ[k];
  end

  assign initAddr  = {ptrHiQ, ptrLoQ};
  assign busCtrl   = busQ;
  assign promiscOn = modeQ[DATA_W-1];

  always_comb begin
    rdData = '0;
    if (curAddr == ADDR_W'(REG_STATUS)) rdData = statusWord;
    else if (curAddr == ADDR_W'(REG_PTR_LO)) rdData = ptrLoQ;
    else if (curAddr == ADDR_W'(REG_PTR_HI)) rdData = ptrHiQ;
    else if (curAddr == ADDR_W'(REG_BUS)) rdData = DATA_W'(busQ);
    else if (curAddr == ADDR_W'(REG_MODE)) rdData = modeQ;
    for (int k = 0; k < FILTER_WORDS; k++)
      if (curAddr == ADDR_W'(FILTER_BASE + k)) rdData = filterQ[k];
  end
endmodule

// File: rtl/eth_csr_port.sv
module eth_csr_port
  import eth_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hostWrEn,
  input  logic                           hostAddrSel,
  input  logic [DATA_W-1:0]              hostWrData,
  output logic [DATA_W-1:0]              hostRdData,
  input  logic                           initDoneEvt,
  input  logic                           txDoneEvt,
  input  logic                           rxDoneEvt,
  input  logic                           memErrEvt,
  input  logic                           missEvt,
  input  logic                           carrierErrEvt,
  input  logic                           babbleEvt,
  output logic                           irqOut,
  output logic                           initCmd,
  output logic                           startCmd,
  output logic                           stopCmd,
  output logic                           txDemandCmd,
  output logic [2*DATA_W-1:0]            initAddr,
  output logic [BUS_W-1:0]               busCtrl,
  output logic [FILTER_WORDS*DATA_W-1:0] filterBits,
  output logic                           promiscOn
);
  wrStrobes_t wrS;
  logic [ADDR_W-1:0] curAddr;
  logic stopNow;
  logic [DATA_W-1:0] statusWord;
  logic [NUM_CAUSE-1:0] evtVec;

  assign evtVec = {babbleEvt, carrierErrEvt, missEvt, memErrEvt,
                   rxDoneEvt, txDoneEvt, initDoneEvt};

  eth_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddrSel(hostAddrSel),
    .addrData(hostWrData[ADDR_W-1:0]), .stopNow(stopNow),
    .curAddr(curAddr), .wrS(wrS)
  );

  eth_csr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrS(wrS), .wrData(hostWrData),
    .curAddr(curAddr), .evtVec(evtVec), .stopNow(stopNow),
    .statusWord(statusWord), .rdData(hostRdData), .irqOut(irqOut),
    .initCmd(initCmd), .startCmd(startCmd), .stopCmd(stopCmd),
    .txDemandCmd(txDemandCmd), .initAddr(initAddr), .busCtrl(busCtrl),
    .filterBits(filterBits), .promiscOn(promiscOn)
  );
endmodule

// File: rtl/eth_csr_port_chk.sv
module eth_csr_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int BUS_W = 3,
  parameter int FW = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostWrEn,
  input logic                 hostAddrSel,
  input logic                 wrStopBit,
  input logic [ADDR_W-1:0]    curAddr,
  input logic [DATA_W-1:0]    statusWord,
  input logic                 stopCmd,
  input logic [BUS_W-1:0]     busCtrl,
  input logic [2*DATA_W-1:0]  initAddr,
  input logic [FW*DATA_W-1:0] filterBits,
  input logic                 promiscOn
);
  logic stopWrite;
  assign stopWrite = hostWrEn && !hostAddrSel && (curAddr == '0) && wrStopBit;

  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostAddrSel) |=> $stable(curAddr));

  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopWrite |=> (statusWord[2] && statusWord[1:0] == 2'b00 &&
                   statusWord[5:3] == 3'b000 && statusWord[14:8] == '0));

  a_r5_stopped_no_cause: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] |-> statusWord[14:8] == '0);

  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[2] |=> ($stable(initAddr) && $stable(filterBits) && $stable(promiscOn)));

  a_r9_bus_default: assert property (@(posedge clk) disable iff (!rstN)
    stopWrite |=> busCtrl == '0);

  a_r11_stop_strobe: assert property (@(posedge clk) disable iff (!rstN)
    stopWrite |=> stopCmd);
endmodule

bind eth_csr_port eth_csr_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(eth_csr_pkg::BUS_W),
  .FW(eth_csr_pkg::FILTER_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddrSel(hostAddrSel),
  .wrStopBit(hostWrData[2]), .curAddr(curAddr), .statusWord(statusWord),
  .stopCmd(stopCmd), .busCtrl(busCtrl), .initAddr(initAddr),
  .filterBits(filterBits), .promiscOn(promiscOn)
);

// File: tb/eth_csr_port_bench.sv
`timescale 1ns/1ps
module eth_csr_port_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, hostWrEn, hostAddrSel;
  logic [15:0] hostWrData, hostRdData;
  logic [6:0] evt;
  logic irqOut, initCmd, startCmd, stopCmd, txDemandCmd, promiscOn;
  logic [31:0] initAddr;
  logic [2:0] busCtrl;
  logic [63:0] filterBits;

  eth_csr_port u_eth_csr_port (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddrSel(hostAddrSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .initDoneEvt(evt[0]), .txDoneEvt(evt[1]), .rxDoneEvt(evt[2]),
    .memErrEvt(evt[3]), .missEvt(evt[4]), .carrierErrEvt(evt[5]),
    .babbleEvt(evt[6]), .irqOut(irqOut), .initCmd(initCmd),
    .startCmd(startCmd), .stopCmd(stopCmd), .txDemandCmd(txDemandCmd),
    .initAddr(initAddr), .busCtrl(busCtrl), .filterBits(filterBits),
    .promiscOn(promiscOn)
  );

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R2";

  // behavioural model state
  bit mInit, mStrt, mStop, mTdmd, mTxOn, mRxOn, mInea;
  bit [6:0] mCause;
  int mAddr;
  bit [15:0] mLo, mHi, mMode;
  bit [2:0] mBus;
  bit [15:0] mFilt [4];
  bit mIs, mSs, mPs, mTs;

  function automatic bit mErr();
    return mCause[3] | mCause[4] | mCause[5] | mCause[6];
  endfunction

  function automatic bit mIntr();
    return mCause[0] | mCause[1] | mCause[2] | mCause[3] | mCause[4] | mCause[6];
  endfunction

  function automatic bit [15:0] mRead(int a);
    bit [15:0] v;
    v = 16'h0;
    if (a == 0) begin
      v[0] = mInit; v[1] = mStrt; v[2] = mStop; v[3] = mTdmd;
      v[4] = mTxOn; v[5] = mRxOn; v[6] = mInea; v[7] = mIntr();
      v[14:8] = mCause; v[15] = mErr();
    end else if (a == 1) v = mLo;
    else if (a == 2) v = mHi;
    else if (a == 3) v = {13'h0, mBus};
    else if (a >= 8 && a <= 11) v = mFilt[a-8];
    else if (a == 15) v = mMode;
    return v;
  endfunction

  task automatic modelReset();
    {mInit, mStrt, mTdmd, mTxOn, mRxOn, mInea} = '0;
    mStop = 1'b1; mCause = '0; mAddr = 0;
    mLo = '0; mHi = '0; mMode = '0; mBus = '0;
    foreach (mFilt[i]) mFilt[i] = '0;
    {mIs, mSs, mPs, mTs} = '0;
  endtask

  task automatic modelStep();
    bit wr0, dw, stopW;
    bit [6:0] acc;
    bit [15:0] d;
    d = hostWrData;
    dw = hostWrEn && !hostAddrSel;
    wr0 = dw && (mAddr == 0);
    stopW = wr0 && d[2];
    acc = (mStop || stopW) ? 7'h0 : evt;
    mPs = stopW;
    mIs = wr0 && d[0] && !d[2];
    mSs = wr0 && d[1] && !d[2];
    mTs = wr0 && d[3] && !d[2];
    if (dw && mStop) begin
      case (mAddr)
        1: mLo = d;
        2: mHi = d;
        3: mBus = d[2:0];
        8, 9, 10, 11: mFilt[mAddr-8] = d;
        15: mMode = d;
        default: ;
      endcase
    end
    if (wr0) mInea = d[6];
    if (stopW) begin
      {mInit, mStrt, mTdmd, mTxOn, mRxOn} = '0;
      mStop = 1'b1; mCause = '0; mBus = '0;
    end else begin
      if (mIs) begin mInit = 1'b1; mStop = 1'b0; end
      if (mSs) begin mStrt = 1'b1; mTxOn = 1'b1; mRxOn = 1'b1; mStop = 1'b0; end
      if (mTs) mTdmd = 1'b1;
      else if (acc[1]) mTdmd = 1'b0;
      for (int i = 0; i < 7; i++) begin
        if (wr0 && d[8+i]) mCause[i] = 1'b0;
        if (acc[i]) mCause[i] = 1'b1;
      end
    end
    if (hostWrEn && hostAddrSel) mAddr = int'(d[3:0]);
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(curReq, "hostRdData", 64'(hostRdData), 64'(mRead(mAddr)));
    chk("R7", "irqOut", 64'(irqOut), 64'(mIntr() && mInea));
    chk("R11", "strobes", 64'({initCmd, startCmd, stopCmd, txDemandCmd}),
        64'({mIs, mSs, mPs, mTs}));
    chk("R9", "busCtrl", 64'(busCtrl), 64'(mBus));
    chk("R8", "initAddr", 64'(initAddr), 64'({mHi, mLo}));
    chk("R10", "filterBits", filterBits, {mFilt[3], mFilt[2], mFilt[1], mFilt[0]});
    chk("R10", "promiscOn", 64'(promiscOn), 64'(mMode[15]));
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic hostWr(bit sel, bit [15:0] d);
    hostWrEn = 1'b1; hostAddrSel = sel; hostWrData = d;
    cycle();
    hostWrEn = 1'b0; hostWrData = '0; evt = '0;
  endtask

  task automatic pulse(bit [6:0] e);
    evt = e;
    cycle();
    evt = '0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired before the run completed");
    finishRun();
  end

  initial begin
    rstN = 1'b0; hostWrEn = 1'b0; hostAddrSel = 1'b0; hostWrData = '0; evt = '0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state
    curReq = "R2";
    compareAll();
    cycle();
    // R1: address selection persists, unassigned numbers
    curReq = "R1";
    hostWr(1, 16'h0001); hostWr(0, 16'h1234);
    hostWr(1, 16'h0002); hostWr(0, 16'h00AB);
    hostWr(1, 16'h0005); hostWr(0, 16'hFFFF); cycle();
    hostWr(1, 16'h000C); hostWr(0, 16'h5A5A);
    hostWr(1, 16'h0001); cycle(); cycle();
    // R9: bus control written while stopped
    curReq = "R9";
    hostWr(1, 16'h0003); hostWr(0, 16'h0007);
    // R10: filter words and promiscuous bit
    curReq = "R10";
    for (int i = 8; i < 12; i++) begin
      hostWr(1, 16'(i)); hostWr(0, 16'hC000 + 16'(i * 16'h0111));
    end
    hostWr(1, 16'h000F); hostWr(0, 16'h8000);
    // R4: INIT together with STOP reads back STOP only; bus control reset
    curReq = "R4";
    hostWr(1, 16'h0000); hostWr(0, 16'h0005);
    hostWr(1, 16'h0003); hostWr(0, 16'h0004);
    hostWr(1, 16'h0000);
    // R3: zero write, INIT, STRT
    curReq = "R3";
    hostWr(0, 16'h0000);
    hostWr(0, 16'h0001);
    pulse(7'b0000001);
    hostWr(0, 16'h0042);
    // R8: config ignored while running
    curReq = "R8";
    hostWr(1, 16'h0001); hostWr(0, 16'h5555);
    hostWr(1, 16'h0003); hostWr(0, 16'h0000);
    hostWr(1, 16'h000F); hostWr(0, 16'h0000);
    hostWr(1, 16'h0000);
    // R5: events, clears, same-cycle event and clear
    curReq = "R5";
    pulse(7'b0000110);
    evt = 7'b0000010; hostWr(0, 16'h0240);
    hostWr(0, 16'h0140);
    hostWr(0, 16'h0040);
    hostWr(0, 16'h0640);
    // R6: error summary, read-only bits
    curReq = "R6";
    pulse(7'b0100000);
    hostWr(0, 16'h80F0);
    // R7: interrupt summary and enable
    curReq = "R7";
    hostWr(0, 16'h7F40);
    pulse(7'b0100000);
    pulse(7'b0001000);
    hostWr(0, 16'h0000);
    hostWr(0, 16'h0040);
    pulse(7'b0010000);
    // R12: transmit demand released by transmit done
    curReq = "R12";
    hostWr(0, 16'h0048);
    cycle();
    pulse(7'b0000010);
    evt = 7'b0000010; hostWr(0, 16'h0048);
    // R4: stop beats a concurrent babble; events ignored while stopped
    curReq = "R4";
    evt = 7'b1000000; hostWr(0, 16'h0004);
    pulse(7'b1111111);
    cycle();
    // R11: back-to-back commands
    curReq = "R11";
    hostWr(0, 16'h0003);
    hostWr(0, 16'h0008);
    hostWr(0, 16'h000F);
    cycle();
    finishRun();
  end
endmodule